// File: doc/BRIEF.md
# Pulse-Width Serial LED Bit Encoder

The block converts 24-bit colour words into a one-wire serial waveform for a daisy chain of addressable LEDs. Every bit takes one fixed-length bit cycle, timed by a free-running counter that counts from zero up to a programmable top value and then wraps. Two compare points inside the cycle give a short pulse and a long pulse. Both pulses start at the same offset. A logic one goes out as the long pulse and a logic zero as the short pulse.

A colour word enters through a valid/ready interface. It is accepted only at the end of a bit cycle in which no bits remain to be sent. The word holds red in its upper byte, green in its middle byte and blue in its lower byte. Each word is sent from its top bit down to bit 0. A frame-last flag goes with the word and closes the frame once that word has been sent. If the source has no word ready when an open frame needs one, the block aborts the frame, raises a one-cycle underrun flag and keeps the line low.

Internally the bit for the next cycle is presented at the wrap. The bit and a frame enable are then re-registered at the point where the long pulse ends. Both values stay stable for the whole of the next bit cycle.

Top module: `ledwire_encoder`

## Requirements
- R1: The bit cycle lasts CYCLE_TOP+1 clocks (46 by default). The internal counter runs 0..CYCLE_TOP and wraps to 0. It is 0 in the first clock after reset release.
- R2: A transmitted 1 drives `led_line` high for LONG_END clocks (22) and a transmitted 0 for SHORT_END clocks (10). The line is low for the rest of the bit cycle. Every pulse rises in the clock where the counter reads 1.
- R3: `pix_data[23:16]` is red, `[15:8]` is green and `[7:0]` is blue. The bits go out in the order bit 23 down to bit 0, with exactly 24 pulses per word.
- R4: `pix_ready` is high only in the last clock of a bit cycle (counter = CYCLE_TOP), and only when all bits of the previous word have been presented. A word is taken only when `pix_valid` and `pix_ready` are both high. A valid word held while ready is low has no effect.
- R5: For a word that opens a frame from idle, the first pulse rises 47 clocks after the clock edge that accepts it.
- R6: Words accepted back to back, including the first word of a new frame accepted straight after a last word, produce pulses whose rising edges are exactly one bit cycle apart, with no gap.
- R7: `busy` is high from the acceptance that opens a frame until the clock after the last pulse of that frame ends. Outside a frame, `led_line` stays low for whole bit cycles.
- R8: If a word without the last flag has been fully presented and no valid word is offered at the next ready point, `underrun` is high for one clock, in the clock after that point. The frame then ends: the already presented bit is still sent, and the line stays low after it.
- R9: While `rst_n` is low, `led_line`, `busy`, `pix_ready` and `underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Colour word offered |
| pix_ready | output | 1 | Word accepted this clock if valid |
| pix_data | input | 24 | Colour word: red, green, blue from top byte down |
| pix_last | input | 1 | Word closes the frame |
| led_line | output | 1 | Pulse-width coded serial output |
| busy | output | 1 | A frame is being presented or driven |
| underrun | output | 1 | One-clock flag: frame aborted for lack of data |

## Verification
On every clock, the assertions check the counter range and wrap, and that every rising edge of the line falls at counter value 1. They also check that every falling edge falls just after one of the two thresholds. Other per-clock checks: ready appears only at the wrap, the line is never high outside `busy`, and `underrun` is a lone pulse right after a wrap. Only the bench scenarios can show the values that depend on data: which width each bit gets and the bit order across the three colours. The same goes for the 47-clock start latency, gap-free transmission across words and frames, and the abort path after an underrun.

// File: rtl/lwe_pkg.sv
`timescale 1ns/1ps
package lwe_pkg;
  localparam int COLOR_W  = 8;
  localparam int N_COLORS = 3;
  localparam int PIX_W    = COLOR_W * N_COLORS;

  // colour word layout; the first field is shifted out first
  typedef struct packed {
    logic [COLOR_W-1:0] red;
    logic [COLOR_W-1:0] green;
    logic [COLOR_W-1:0] blue;
  } rgb_t;
endpackage

// File: rtl/lwe_bit_timer.sv
`timescale 1ns/1ps
module lwe_bit_timer #(
  parameter int CYCLE_TOP = 45,
  parameter int SHORT_END = 10,
  parameter int LONG_END  = 22,
  localparam int CNT_W    = $clog2(CYCLE_TOP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             short_on,
  output logic             long_on,
  output logic             capture
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == CNT_W'(CYCLE_TOP)) cnt_d = '0;
    else                            cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt      = cnt_q;
  assign wrap     = (cnt_q == CNT_W'(CYCLE_TOP));
  assign short_on = (cnt_q <  CNT_W'(SHORT_END));
  assign long_on  = (cnt_q <  CNT_W'(LONG_END));
  // first tick after the long pulse has ended: both pulses are low here
  assign capture  = (cnt_q == CNT_W'(LONG_END));
endmodule

// File: rtl/lwe_pixel_serializer.sv
`timescale 1ns/1ps
module lwe_pixel_serializer
  import lwe_pkg::*;
#(
  localparam int LEFT_W = $clog2(PIX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             pix_last,
  output logic             pix_ready,
  output logic             pres_bit,
  output logic             pres_en,
  output logic             underrun
);
  rgb_t             px;
  logic [PIX_W-1:0] load_word;
  logic [PIX_W-1:0] shreg_q, shreg_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic             bit_q, bit_d;
  logic             en_q, en_d;
  logic             last_q, last_d;
  logic             und_q, und_d;
  logic             empty;

  assign px        = rgb_t'(pix_data);
  assign load_word = {px.red, px.green, px.blue};
  assign empty     = (left_q == '0);
  assign pix_ready = wrap & empty;

  always_comb begin
    shreg_d = shreg_q;
    left_d  = left_q;
    bit_d   = bit_q;
    en_d    = en_q;
    last_d  = last_q;
    und_d   = 1'b0;
    if (wrap) begin
      if (!empty) begin
        bit_d   = shreg_q[PIX_W-1];
        shreg_d = {shreg_q[PIX_W-2:0], 1'b0};
        left_d  = left_q - LEFT_W'(1);
      end else if (pix_valid) begin
        bit_d   = load_word[PIX_W-1];
        shreg_d = {load_word[PIX_W-2:0], 1'b0};
        left_d  = LEFT_W'(PIX_W - 1);
        en_d    = 1'b1;
        last_d  = pix_last;
      end else begin
        en_d    = 1'b0;
        und_d   = en_q & ~last_q;
      end
    end
  end

  // shift path advances only at the bit-cycle boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      left_q  <= '0;
      bit_q   <= 1'b0;
      en_q    <= 1'b0;
      last_q  <= 1'b0;
    end else if (wrap) begin
      shreg_q <= shreg_d;
      left_q  <= left_d;
      bit_q   <= bit_d;
      en_q    <= en_d;
      last_q  <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) und_q <= 1'b0;
    else        und_q <= und_d;
  end

  assign pres_bit = bit_q;
  assign pres_en  = en_q;
  assign underrun = und_q;
endmodule

// File: rtl/lwe_pulse_stage.sv
`timescale 1ns/1ps
module lwe_pulse_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic short_on,
  input  logic long_on,
  input  logic pres_bit,
  input  logic pres_en,
  output logic line,
  output logic drive_en
);
  logic bit_q, en_q, line_q, line_d;

  // selected pulse, gated by the frame enable
  always_comb begin
    line_d = en_q & (bit_q ? long_on : short_on);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      en_q  <= 1'b0;
    end else if (capture) begin
      bit_q <= pres_bit;
      en_q  <= pres_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_d;
  end

  assign line     = line_q;
  assign drive_en = en_q;
endmodule

// File: rtl/ledwire_encoder.sv
`timescale 1ns/1ps
module ledwire_encoder
  import lwe_pkg::*;
#(
  parameter int CYCLE_TOP = 45,
  parameter int SHORT_END = 10,
  parameter int LONG_END  = 22,
  localparam int CNT_W    = $clog2(CYCLE_TOP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             pix_last,
  output logic             led_line,
  output logic             busy,
  output logic             underrun
);
  logic [CNT_W-1:0] bit_cnt;
  logic wrap, short_on, long_on, capture;
  logic pres_bit, pres_en, drive_en;

  lwe_bit_timer #(
    .CYCLE_TOP(CYCLE_TOP),
    .SHORT_END(SHORT_END),
    .LONG_END (LONG_END)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (bit_cnt),
    .wrap    (wrap),
    .short_on(short_on),
    .long_on (long_on),
    .capture (capture)
  );

  lwe_pixel_serializer u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap     (wrap),
    .pix_valid(pix_valid),
    .pix_data (pix_data),
    .pix_last (pix_last),
    .pix_ready(pix_ready),
    .pres_bit (pres_bit),
    .pres_en  (pres_en),
    .underrun (underrun)
  );

  lwe_pulse_stage u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .short_on(short_on),
    .long_on (long_on),
    .pres_bit(pres_bit),
    .pres_en (pres_en),
    .line    (led_line),
    .drive_en(drive_en)
  );

  assign busy = pres_en | drive_en;
endmodule

// File: rtl/ledwire_encoder_chk.sv
`timescale 1ns/1ps
module ledwire_encoder_chk #(
  parameter int CYCLE_TOP = 45,
  parameter int SHORT_END = 10,
  parameter int LONG_END  = 22,
  localparam int CNT_W    = $clog2(CYCLE_TOP + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             pix_ready,
  input logic             led_line,
  input logic             busy,
  input logic             underrun
);
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CYCLE_TOP));

  p_cnt_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(CYCLE_TOP)) |=> (cnt == '0));

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != CNT_W'(CYCLE_TOP)) |=> (cnt == $past(cnt) + CNT_W'(1)));

  p_rise_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(led_line) |-> (cnt == CNT_W'(1)));

  p_fall_at_threshold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(led_line) |-> (cnt == CNT_W'(SHORT_END + 1) || cnt == CNT_W'(LONG_END + 1)));

  p_ready_at_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (cnt == CNT_W'(CYCLE_TOP)));

  p_line_within_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    led_line |-> busy);

  p_underrun_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  p_underrun_after_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (cnt == '0));
endmodule

bind ledwire_encoder ledwire_encoder_chk #(
  .CYCLE_TOP(CYCLE_TOP),
  .SHORT_END(SHORT_END),
  .LONG_END (LONG_END)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt      (bit_cnt),
  .pix_ready(pix_ready),
  .led_line (led_line),
  .busy     (busy),
  .underrun (underrun)
);

// File: tb/tb_ledwire_encoder.sv
`timescale 1ns/1ps
module tb_ledwire_encoder;
  localparam int TOP = 45;
  localparam int TS  = 10;
  localparam int TL  = 22;
  localparam int PW  = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_valid = 1'b0;
  logic [PW-1:0] pix_data = '0;
  logic          pix_last = 1'b0;
  logic          pix_ready, led_line, busy, underrun;

  always #2.5 clk = ~clk;

  ledwire_encoder dut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .pix_last(pix_last), .led_line(led_line),
    .busy(busy), .underrun(underrun)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (clock %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // ---------------- behavioural reference (queue of pending bits) ----------
  int m_cnt = 0;
  bit m_q[$];
  bit m_pb, m_pe, m_last, m_bit, m_en, m_line, m_und;
  bit t_wrap, t_empty, t_line, t_und;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_q.delete();
      m_pb = 0; m_pe = 0; m_last = 0; m_bit = 0; m_en = 0; m_line = 0; m_und = 0;
    end else begin
      t_wrap  = (m_cnt == TOP);
      t_empty = (m_q.size() == 0);
      t_line  = m_en && (m_bit ? (m_cnt < TL) : (m_cnt < TS));
      t_und   = t_wrap && t_empty && !pix_valid && m_pe && !m_last;
      if (m_cnt == TL) begin m_bit = m_pb; m_en = m_pe; end
      if (t_wrap) begin
        if (!t_empty) m_pb = m_q.pop_front();
        else if (pix_valid) begin
          for (int i = PW - 1; i >= 0; i--) m_q.push_back(pix_data[i]);
          m_pb = m_q.pop_front(); m_pe = 1; m_last = pix_last;
        end else m_pe = 0;
      end
      m_line = t_line;
      m_und  = t_und;
      m_cnt  = t_wrap ? 0 : m_cnt + 1;
    end
    if (cyc > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // ---------------- independent pulse decoder and per-clock compare --------
  bit exp_bits[$];
  bit prev_line = 0, rise_ok = 0, lat_pending = 0;
  int run = 0, last_rise = 0, acc_cyc = 0, last_rdy = -1, und_count = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(led_line == m_line, "R2 line vs model", led_line, m_line);
      chk(pix_ready == (m_cnt == TOP && m_q.size() == 0), "R4 ready vs model",
          pix_ready, (m_cnt == TOP && m_q.size() == 0));
      chk(busy == (m_pe | m_en), "R7 busy vs model", busy, m_pe | m_en);
      chk(underrun == m_und, "R8 underrun vs model", underrun, m_und);
      if (underrun) und_count++;
      if (pix_ready) begin
        if (last_rdy >= 0) chk((cyc - last_rdy) % (TOP + 1) == 0, "R1 ready spacing", cyc - last_rdy, TOP + 1);
        last_rdy = cyc;
      end
      if (led_line && !prev_line) begin
        if (rise_ok) chk(cyc - last_rise == TOP + 1, "R6 rise spacing", cyc - last_rise, TOP + 1);
        if (lat_pending) begin
          chk(cyc - acc_cyc == 47, "R5 start latency", cyc - acc_cyc, 47);
          lat_pending = 0;
        end
        last_rise = cyc; rise_ok = 1;
      end
      if (led_line) run++;
      else if (prev_line) begin
        if (exp_bits.size() == 0) chk(0, "R3 unexpected pulse", run, 0);
        else begin
          automatic bit b = exp_bits.pop_front();
          chk(run == (b ? TL : TS), "R3 pulse width for bit", run, b ? TL : TS);
        end
        run = 0;
      end
      if (!busy) rise_ok = 0;
      prev_line = led_line;
    end
  end

  task automatic send(input logic [PW-1:0] px, input bit lst);
    @(negedge clk);
    pix_valid = 1'b1; pix_data = px; pix_last = lst;
    while (!pix_ready) @(negedge clk);
    if (!busy) begin lat_pending = 1; acc_cyc = cyc + 1; end
    for (int i = PW - 1; i >= 0; i--) exp_bits.push_back(px[i]);
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic drain();
    while (busy) @(negedge clk);
    repeat (100) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state of every output
    chk(led_line == 0, "R9 line in reset", led_line, 0);
    chk(busy == 0, "R9 busy in reset", busy, 0);
    chk(pix_ready == 0, "R9 ready in reset", pix_ready, 0);
    chk(underrun == 0, "R9 underrun in reset", underrun, 0);
    rst_n = 1'b1;
    repeat (150) @(negedge clk);             // idle: R1 spacing, line low
    send(24'hA53CF0, 1'b0);                  // two words, one frame (R3, R5, R6)
    send(24'h0180FF, 1'b1);
    drain();                                 // R7 frame end
    send(24'hFFFFFF, 1'b1);                  // back-to-back frames (R6)
    send(24'h000000, 1'b1);
    drain();
    send(24'h5AC381, 1'b0);                  // no follow-up: underrun (R8)
    drain();
    chk(und_count == 1, "R8 underrun pulse count", und_count, 1);
    chk(exp_bits.size() == 0, "R3 all bits transmitted", exp_bits.size(), 0);
    chk(led_line == 0 && busy == 0, "R7 idle after frames", led_line + busy, 0);
    done = 1'b1;
    finish_run();
  end
endmodule